// File: doc/BRIEF.md
# Registered Integer Adder/Subtracter

This block adds or subtracts two integer operands and registers the result. It is meant as a building block for loadable counters and accumulators. The two operands have independent widths, and each can be signed or unsigned. Each operand is widened to the result width before the operation. The operation is chosen by a parameter: always add, always subtract, or selected each cycle by an input pin.

Several features can be switched on by parameters:
- a carry/borrow input and a carry/borrow output, whose active level in subtract mode is set by a parameter;
- a load path that places operand B directly into the result register;
- a clock enable;
- a fixed constant in place of operand B.

The result register starts from a parameter-given value after reset. The total latency is a parameter, and the block inserts pipeline stages to match it. The operation select, load select and carry input travel down the pipeline together with the operand data.

Top module: `addsub_reg`

## Requirements
- R1: After a clock edge with `rst_n` low, `s` equals the parameter `S_INIT` and `c_out` is 0. All internal pipeline stages hold all-zero operands and controls.
- R2: An operand whose signed parameter is 1 is sign-extended to `OUT_WIDTH` before the operation; otherwise it is zero-extended.
- R3: When adding, `{c_out, s}` equals the low `OUT_WIDTH+1` bits of `a_ext + b_ext + c_in`. Carry in and carry out are both active-high.
- R4: When subtracting, the bit-`OUT_WIDTH` borrow of `a_ext - b_ext - borrow_in` is computed, and `s` takes the low bits. The borrow is asserted on `c_in` and reported on `c_out` at the level set by `BORROW_ACTIVE_HIGH` (1 = high, 0 = low).
- R5: With `OP_MODE` = runtime, `add_sel` = 1 adds and `add_sel` = 0 subtracts. With a fixed mode, `add_sel` has no effect.
- R6: With `HAS_BYPASS` = 1, a sampled `bypass` = 1 loads `s` with `b`, extended per R2. It loads `c_out` with 0. This takes priority over the arithmetic result.
- R7: With `HAS_CE` = 1, `ce` = 0 freezes `s`, `c_out` and every pipeline stage. With `HAS_CE` = 0, `ce` is ignored.
- R8: Inputs sampled at an enabled clock edge appear on `s` and `c_out` at the `LATENCY`-th enabled edge, counting the sampling edge as the first.
- R9: With `B_IS_CONST` = 1, the arithmetic uses `B_CONST` in place of `b`. The `b` port then only supplies load data for R6.
- R10: With `HAS_CIN` = 0, `c_in` is ignored: no carry is added and no borrow is taken. With `HAS_COUT` = 0, `c_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable (used when `HAS_CE` = 1) |
| add_sel | input | 1 | Runtime operation select: 1 add, 0 subtract |
| bypass | input | 1 | Load `b` into `s` (used when `HAS_BYPASS` = 1) |
| c_in | input | 1 | Carry in, or borrow in at the level set by the parameter |
| a | input | A_WIDTH | Operand A |
| b | input | B_WIDTH | Operand B, or load data |
| s | output | OUT_WIDTH | Registered result |
| c_out | output | 1 | Registered carry, or borrow at the level set by the parameter |

## Verification
Each result is due at the `LATENCY`-th enabled rising edge, counting the edge that samples its inputs as the first. That is the third edge in the main configuration and the same edge in the second configuration. The bench model pushes the expected `{c_out, s}` for every sampled input set into a queue. The queue is preloaded with `LATENCY-1` entries computed from all-zero stimulus, which is the pipeline content after reset. The queue advances only on edges where the enable is high, so frozen cycles shift nothing. Outputs are compared on every falling edge against the entry taken at the preceding rising edge.

// File: rtl/addsub_pkg.sv
// Package: shared types and helpers for the registered adder/subtracter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package addsub_pkg;

    // Operation choice fixed at build time or taken from a pin.
    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_SUB     = 2'd1,
        OP_RUNTIME = 2'd2
    } op_mode_e;

    // Map a logical "asserted" flag to a pin level with selectable polarity.
    function automatic logic to_level(input logic asserted, input bit active_high);
        return active_high ? asserted : ~asserted;
    endfunction

    // Map a pin level with selectable polarity back to a logical flag.
    function automatic logic from_level(input logic level, input bit active_high);
        return active_high ? level : ~level;
    endfunction

endpackage

// File: rtl/addsub_extend.sv
// Module: widens an operand to the result width.
// Does: sign-extends when IS_SIGNED is set, zero-extends otherwise.
// Assumes: OUT_W >= IN_W.
module addsub_extend #(
    parameter int IN_W      = 8,
    parameter int OUT_W     = 10,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int PAD = OUT_W - IN_W;

    generate
        if (PAD == 0) begin : g_same
            // Same width: pass straight through.
            assign dout = din;
        end else if (IS_SIGNED) begin : g_sext
            // Replicate the sign bit into the pad.
            assign dout = {{PAD{din[IN_W-1]}}, din};
        end else begin : g_zext
            // Fill the pad with zeros.
            assign dout = {{PAD{1'b0}}, din};
        end
    endgenerate
endmodule

// File: rtl/addsub_delay.sv
// Module: enable-gated delay line of DEPTH stages.
// Does: shifts a bundle one stage per enabled edge; DEPTH = 0 is a wire.
// Assumes: synchronous active-low reset clears every stage to zero.
module addsub_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            // No pipeline stage asked for.
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];

            // Shift the bundle forward on each enabled edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else if (en) begin
                    stg[0] <= din;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end

            assign dout = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/addsub_core.sv
// Module: combinational add/subtract with carry/borrow.
// Does: computes a+b+carry or a-b-borrow on W+1 bits and returns the
//       top bit as a logical carry (add) or borrow (subtract).
// Assumes: carry_in is already a logical flag (1 = present).
module addsub_core #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_add,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic [W:0] full;

    // One W+1 bit adder or subtracter chosen by the mode flag.
    always_comb begin
        if (do_add)
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_in};
        else
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, carry_in};
    end

    assign sum       = full[W-1:0];
    assign carry_out = full[W];
endmodule

// File: rtl/addsub_reg.sv
// Module: registered integer adder/subtracter (top).
// Does: delays operands and controls by LATENCY-1 stages, computes the
//       sum or difference (or passes B on a load), and registers s/c_out.
// Assumes: LATENCY >= 1; OUT_WIDTH >= A_WIDTH and OUT_WIDTH >= B_WIDTH;
//          B_CONST fits in B_WIDTH bits.
module addsub_reg #(
    parameter int                      A_WIDTH            = 8,
    parameter bit                      A_SIGNED           = 1'b1,
    parameter int                      B_WIDTH            = 6,
    parameter bit                      B_SIGNED           = 1'b0,
    parameter int                      OUT_WIDTH          = 10,
    parameter addsub_pkg::op_mode_e    OP_MODE            = addsub_pkg::OP_RUNTIME,
    parameter bit                      HAS_CIN            = 1'b1,
    parameter bit                      HAS_COUT           = 1'b1,
    parameter bit                      BORROW_ACTIVE_HIGH = 1'b0,
    parameter bit                      HAS_BYPASS         = 1'b1,
    parameter bit                      HAS_CE             = 1'b1,
    parameter bit                      B_IS_CONST         = 1'b0,
    parameter logic [B_WIDTH-1:0]      B_CONST            = '0,
    parameter logic [OUT_WIDTH-1:0]    S_INIT             = '0,
    parameter int                      LATENCY            = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 add_sel,
    input  logic                 bypass,
    input  logic                 c_in,
    input  logic [A_WIDTH-1:0]   a,
    input  logic [B_WIDTH-1:0]   b,
    output logic [OUT_WIDTH-1:0] s,
    output logic                 c_out
);
    import addsub_pkg::*;

    localparam int  PIPE_DEPTH = LATENCY - 1;
    localparam int  BUNDLE_W   = A_WIDTH + B_WIDTH + 3;
    localparam bit  IS_RUNTIME = (OP_MODE == OP_RUNTIME);
    localparam bit  FIXED_ADD  = (OP_MODE == OP_ADD);

    logic                 ce_eff;
    logic                 byp_in, add_in, cin_in;
    logic [BUNDLE_W-1:0]  bundle_in, bundle_out;
    logic                 d_byp, d_add, d_cin;
    logic [A_WIDTH-1:0]   d_a;
    logic [B_WIDTH-1:0]   d_b;
    logic [B_WIDTH-1:0]   arith_b;
    logic [OUT_WIDTH-1:0] a_ext, b_ext, byp_ext;
    logic                 add_now, carry_log;
    logic [OUT_WIDTH-1:0] sum;
    logic                 cy_log;
    logic [OUT_WIDTH-1:0] s_next;
    logic                 cout_next;

    // Enable is forced high when the option is off.
    assign ce_eff = ce | ~HAS_CE;

    // Mask disabled controls so the pipeline only carries live values.
    assign byp_in    = bypass  & HAS_BYPASS;
    assign add_in    = add_sel & IS_RUNTIME;
    assign cin_in    = c_in    & HAS_CIN;
    assign bundle_in = {byp_in, add_in, cin_in, b, a};

    addsub_delay #(
        .W     (BUNDLE_W),
        .DEPTH (PIPE_DEPTH)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ce_eff),
        .din   (bundle_in),
        .dout  (bundle_out)
    );

    assign {d_byp, d_add, d_cin, d_b, d_a} = bundle_out;

    // Constant operand replaces the port value on the arithmetic path only.
    assign arith_b = B_IS_CONST ? B_CONST : d_b;

    addsub_extend #(.IN_W(A_WIDTH), .OUT_W(OUT_WIDTH), .IS_SIGNED(A_SIGNED))
        u_ext_a (.din(d_a), .dout(a_ext));
    addsub_extend #(.IN_W(B_WIDTH), .OUT_W(OUT_WIDTH), .IS_SIGNED(B_SIGNED))
        u_ext_b (.din(arith_b), .dout(b_ext));
    addsub_extend #(.IN_W(B_WIDTH), .OUT_W(OUT_WIDTH), .IS_SIGNED(B_SIGNED))
        u_ext_l (.din(d_b), .dout(byp_ext));

    // Resolve the operation and the logical carry/borrow for this stage.
    always_comb begin
        add_now   = FIXED_ADD | (IS_RUNTIME & d_add);
        carry_log = HAS_CIN & (add_now ? d_cin
                                       : from_level(d_cin, BORROW_ACTIVE_HIGH));
    end

    addsub_core #(.W(OUT_WIDTH)) u_core (
        .a         (a_ext),
        .b         (b_ext),
        .do_add    (add_now),
        .carry_in  (carry_log),
        .sum       (sum),
        .carry_out (cy_log)
    );

    // Pick load data over arithmetic and set the flag polarity.
    always_comb begin
        if (d_byp) begin
            s_next    = byp_ext;
            cout_next = 1'b0;
        end else begin
            s_next    = sum;
            cout_next = HAS_COUT & (add_now ? cy_log
                                            : to_level(cy_log, BORROW_ACTIVE_HIGH));
        end
    end

    // Output register with power-up value and enable gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s     <= S_INIT;
            c_out <= 1'b0;
        end else if (ce_eff) begin
            s     <= s_next;
            c_out <= cout_next;
        end
    end
endmodule

// File: rtl/addsub_reg_chk.sv
// Module: property checker bound to addsub_reg.
// Does: checks reset value, freeze, load priority and two arithmetic
//       identities between the last pipeline stage and the output register.
// Assumes: stage_* inputs are the values presented to the output register.
module addsub_reg_chk #(
    parameter int                   OUT_WIDTH          = 10,
    parameter logic [OUT_WIDTH-1:0] S_INIT             = '0,
    parameter bit                   BORROW_ACTIVE_HIGH = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce_eff,
    input logic [OUT_WIDTH-1:0] s,
    input logic                 c_out,
    input logic                 stage_byp,
    input logic [OUT_WIDTH-1:0] stage_byp_data,
    input logic                 stage_sub,
    input logic [OUT_WIDTH-1:0] stage_a_ext,
    input logic [OUT_WIDTH-1:0] stage_b_ext,
    input logic                 stage_borrow
);
    logic [OUT_WIDTH-1:0] diff;
    assign diff = stage_a_ext - stage_b_ext;

    // R1: first cycle out of reset shows the power-up value.
    p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (s == S_INIT && !c_out));

    // R7: a disabled cycle leaves the outputs untouched.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_eff |=> ($stable(s) && $stable(c_out)));

    // R6: a load presented to the register wins over arithmetic.
    p_load_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_eff && stage_byp) |=> (s == $past(stage_byp_data) && !c_out));

    // R4: subtract with no borrow in and a >= b gives no borrow out.
    p_no_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_eff && !stage_byp && stage_sub && !stage_borrow &&
         stage_a_ext >= stage_b_ext)
        |=> (s == $past(diff) && c_out == !BORROW_ACTIVE_HIGH));

    // R3: adding zero with no carry returns operand A and no carry.
    p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_eff && !stage_byp && !stage_sub && !stage_borrow &&
         stage_b_ext == '0)
        |=> (s == $past(stage_a_ext) && !c_out));
endmodule

bind addsub_reg addsub_reg_chk #(
    .OUT_WIDTH          (OUT_WIDTH),
    .S_INIT             (S_INIT),
    .BORROW_ACTIVE_HIGH (BORROW_ACTIVE_HIGH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_eff         (ce_eff),
    .s              (s),
    .c_out          (c_out),
    .stage_byp      (d_byp),
    .stage_byp_data (byp_ext),
    .stage_sub      (~add_now),
    .stage_a_ext    (a_ext),
    .stage_b_ext    (b_ext),
    .stage_borrow   (carry_log)
);

// File: tb/sim_addsub_reg.sv
// Bench: two configurations against a behavioural queue model.
module sim_addsub_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b1, add_sel = 1'b0, bypass = 1'b0, c_in = 1'b0;
    logic [7:0] a = '0;
    logic [5:0] b = '0;
    logic [3:0] b1 = '0;
    logic [9:0] s0;
    logic       c0;
    logic [3:0] s1;
    logic       c1;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Main: 8-bit signed A, 6-bit unsigned B, 10-bit result, runtime mode,
    // active-low borrow, load, enable, latency 3.
    addsub_reg #(
        .A_WIDTH(8), .A_SIGNED(1'b1), .B_WIDTH(6), .B_SIGNED(1'b0),
        .OUT_WIDTH(10), .OP_MODE(addsub_pkg::OP_RUNTIME),
        .HAS_CIN(1'b1), .HAS_COUT(1'b1), .BORROW_ACTIVE_HIGH(1'b0),
        .HAS_BYPASS(1'b1), .HAS_CE(1'b1), .B_IS_CONST(1'b0),
        .B_CONST(6'd0), .S_INIT(10'h155), .LATENCY(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .add_sel(add_sel), .bypass(bypass),
        .c_in(c_in), .a(a), .b(b), .s(s0), .c_out(c0)
    );

    // Second: 4-bit unsigned fixed add of constant 5, no carry in, no
    // enable, no load, latency 1.
    addsub_reg #(
        .A_WIDTH(4), .A_SIGNED(1'b0), .B_WIDTH(4), .B_SIGNED(1'b0),
        .OUT_WIDTH(4), .OP_MODE(addsub_pkg::OP_ADD),
        .HAS_CIN(1'b0), .HAS_COUT(1'b1), .BORROW_ACTIVE_HIGH(1'b1),
        .HAS_BYPASS(1'b0), .HAS_CE(1'b0), .B_IS_CONST(1'b1),
        .B_CONST(4'b0101), .S_INIT(4'hF), .LATENCY(1)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .add_sel(add_sel), .bypass(bypass),
        .c_in(c_in), .a(a[3:0]), .b(b1), .s(s1), .c_out(c1)
    );

    int         n_chk = 0, n_fail = 0;
    string      tag = "R1";
    bit         checking = 1'b0;
    logic [10:0] exp0;
    logic [4:0]  exp1;
    logic [10:0] q[$];

    // Expected {c_out, s} of the main configuration for one input set.
    function automatic logic [10:0] ref0(input logic [7:0] ta, input logic [5:0] tb,
                                         input logic tadd, input logic tbyp,
                                         input logic tcin);
        int ea, full;
        logic cy;
        ea = int'($signed(ta)) & 1023;
        if (tbyp) return {1'b0, 10'(tb)};
        if (tadd) begin
            full = ea + int'(tb) + int'(tcin);
            cy   = (full >= 1024);
        end else begin
            full = ea - int'(tb) - (tcin ? 0 : 1);
            cy   = !(full < 0);
        end
        return {cy, 10'(full & 1023)};
    endfunction

    // Expected {c_out, s} of the second configuration.
    function automatic logic [4:0] ref1(input logic [3:0] ta);
        int full;
        full = int'(ta) + 5;
        return 5'(full);
    endfunction

    // Model: queue of pending results, advanced only on enabled edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp0 <= {1'b0, 10'h155};
            exp1 <= {1'b0, 4'hF};
            q.delete();
            repeat (2) q.push_back(ref0(8'd0, 6'd0, 1'b0, 1'b0, 1'b0));
        end else begin
            if (ce) begin
                q.push_back(ref0(a, b, add_sel, bypass, c_in));
                exp0 <= q.pop_front();
            end
            exp1 <= ref1(a[3:0]);
        end
    end

    // Compare both configurations on every falling edge.
    always @(negedge clk) begin
        if (checking) begin
            n_chk++;
            if ({c0, s0} !== exp0) begin
                n_fail++;
                $display("FAIL %s u0 {c_out,s} actual %h expected %h", tag, {c0, s0}, exp0);
            end
            n_chk++;
            if ({c1, s1} !== exp1) begin
                n_fail++;
                $display("FAIL R9/R10 u1 {c_out,s} actual %h expected %h", {c1, s1}, exp1);
            end
        end
    end

    task automatic drive(input logic [7:0] ta, input logic [5:0] tb, input logic tadd,
                         input logic tbyp, input logic tcin, input logic tce);
        @(negedge clk);
        #1;
        a = ta; b = tb; add_sel = tadd; bypass = tbyp; c_in = tcin; ce = tce;
        b1 = ~ta[3:0];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 checking = 1'b1;
        @(negedge clk); #1 rst_n = 1'b1;
        tag = "R8";
        drive(8'h01, 6'h02, 1'b1, 1'b0, 1'b0, 1'b1);
        drive(8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        drive(8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        tag = "R3";
        for (int i = 0; i < 16; i++)
            drive(8'(i * 29 + 3), 6'(i * 7), 1'b1, 1'b0, i[0], 1'b1);
        drive(8'hFF, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b1);
        tag = "R2";
        for (int i = 0; i < 8; i++)
            drive(8'(8'h80 + i * 13), 6'(i * 5), i[1], 1'b0, 1'b1, 1'b1);
        tag = "R4";
        for (int i = 0; i < 12; i++)
            drive(8'(i * 3), 6'(40 - i * 4), 1'b0, 1'b0, i[0], 1'b1);
        drive(8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        drive(8'h00, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        tag = "R5";
        for (int i = 0; i < 10; i++)
            drive(8'(i * 17 + 9), 6'(i * 11), i[0], 1'b0, i[1], 1'b1);
        tag = "R6";
        for (int i = 0; i < 6; i++)
            drive(8'(i * 41), 6'(i * 9 + 1), i[0], 1'b1, i[1], 1'b1);
        drive(8'h10, 6'h3F, 1'b1, 1'b1, 1'b1, 1'b1);
        tag = "R7";
        for (int i = 0; i < 6; i++)
            drive(8'(i * 23 + 1), 6'(i * 3), i[0], i[1], 1'b1, 1'b0);
        drive(8'h22, 6'h05, 1'b1, 1'b0, 1'b0, 1'b1);
        drive(8'h33, 6'h06, 1'b0, 1'b0, 1'b1, 1'b0);
        drive(8'h44, 6'h07, 1'b1, 1'b0, 1'b0, 1'b1);
        tag = "R8";
        repeat (4) drive(8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        tag = "R1";
        @(negedge clk); #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1 checking = 1'b0;
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end
endmodule